// File: doc/BRIEF.md
# Multichannel Conversion Sequencer

The sequencer schedules conversions for up to four channels that are sampled at the same instant, and it emits their results as one-cycle FIFO write strobes in a fixed channel order. Raw channel values come from input ports that stand in for the analog front end. Each value passes through a delay line of `DEPTH` slots (default 8). The delay line models the latency of a pipelined converter, and it advances once per conversion tick.

Two modes exist. In single mode, a falling edge on `start_n` freezes every channel input at once, and the block then converts the selected channels one per internal tick. The internal tick comes from an oscillator divider of `OSC_DIV` system clocks (default 8, about 160 ns at 50 MHz). In continuous mode the oscillator stays off, and every rising edge of the external `conv_clk` pushes one value into the delay line. The channel index wraps at the selected count, and a new hold happens each time the index returns to channel 0.

The controller has four states:
- `ST_IDLE`: waiting.
- `ST_CONT`: free-running on the external clock.
- `ST_SCAN`: single-mode injection of the held channels.
- `ST_DRAIN`: single-mode ticks that empty the delay line.

The transitions are:
- IDLE→CONT when continuous mode is selected.
- IDLE→SCAN on a start edge in single mode.
- CONT→IDLE when single mode is selected; this transition flushes the delay line.
- SCAN→DRAIN on the tick that injects the last selected channel.
- DRAIN→IDLE on the tick that writes the last result.

Top module: `conv_sequencer`

## Requirements
- R1: `mode_single`=1 selects single mode and 0 selects continuous mode. In continuous mode a falling edge on `start_n` neither starts a sequence nor sets `busy_err`.
- R2: In single mode, a high-to-low edge on `start_n` while idle captures every channel input on one clock edge. Channel c is `ch_sample[c*DW +: DW]`. The written results carry those captured values even if the inputs change afterwards.
- R3: In single mode, the internal tick occurs every `OSC_DIV` clocks after the edge that detects the start. The result for channel i (counting from 0) is visible on `fifo_wr` (DEPTH+1+i)*OSC_DIV clocks after that edge. Exactly n writes follow for n selected channels.
- R4: In continuous mode, each rising edge of `conv_clk` advances the delay line by one slot. Each write is a `fifo_wr` pulse one clock long. After T edges from an empty line, T-DEPTH writes have occurred.
- R5: A `chan_sel_cnt` value v scans channels 0 to v, so each sample set has v+1 results and each channel gets 1/(v+1) of the tick rate. In continuous mode, set s (counting from 0) holds the inputs present at edge s*(v+1)+1.
- R6: Within a set, results are written in ascending channel order starting at 0, and `fifo_chan` carries the channel number.
- R7: A value injected on continuous tick k is written on tick k+DEPTH and is visible one clock after that tick's edge.
- R8: `busy` is high from the start-detecting edge until the last single-mode write. `busy` falls in the same cycle that `fifo_wr` shows the last result.
- R9: A start edge that arrives while `busy` is high is ignored, so the write count and timing are unchanged. Such an edge sets `busy_err`, which stays high until reset.
- R10: `chan_sel_cnt` is sampled only at the hold instant. A change made in the middle of a set takes effect at the next set.
- R11: Leaving continuous mode for single mode discards every value still in the delay line.
- R12: After reset, `fifo_wr`, `busy` and `busy_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_single | input | 1 | 1 selects single mode, 0 selects continuous mode |
| chan_sel_cnt | input | CW | Number of channels minus one |
| start_n | input | 1 | Single-mode start; acts on a falling edge |
| conv_clk | input | 1 | External conversion clock, sampled by clk |
| ch_sample | input | NCH*DW | Live channel values, channel c at bits c*DW |
| fifo_wr | output | 1 | One-cycle FIFO write strobe |
| fifo_data | output | DW | Result written with the strobe |
| fifo_chan | output | CW | Channel number of the result |
| busy | output | 1 | Single-mode sequence in progress |
| busy_err | output | 1 | Sticky flag: a start edge arrived while busy |

## Verification
The bench sweeps every channel count in both modes. A design that miscounts the wrap would repeat or skip a channel, and one that captured per tick rather than per set would write values from different edges within one set. Each write time is checked against the exact tick arithmetic, so a delay line one slot short or long shows up at once. Further runs do the following:
- Change the channel count in the middle of a set; a design that sampled it live would truncate the set early.
- Enter single mode with a full delay line; without a flush, stale values would leak out as extra writes.
- Fire a second start during a sequence; a design that restarted would emit extra or shifted results.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONT  = 2'd1,
        ST_SCAN  = 2'd2,
        ST_DRAIN = 2'd3
    } seq_state_t;
endpackage

// File: rtl/conv_tick_gen.sv
module conv_tick_gen #(
    parameter int OSC_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_run,
    input  logic ext_sel,
    input  logic conv_clk,
    output logic tick
);
    localparam int OW = (OSC_DIV > 1) ? $clog2(OSC_DIV) : 1;
    localparam logic [OW-1:0] OSC_LAST = OW'(OSC_DIV - 1);

    logic [OW-1:0] osc_cnt;
    logic          cclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_cnt <= '0;
            cclk_q  <= 1'b0;
        end else begin
            cclk_q <= conv_clk;
            if (!osc_run || osc_cnt == OSC_LAST) begin
                osc_cnt <= '0;
            end else begin
                osc_cnt <= osc_cnt + 1'b1;
            end
        end
    end

    // external mode: rising edge of the sampled conversion clock
    // internal mode: divider terminal count while the oscillator runs
    assign tick = ext_sel ? (conv_clk & ~cclk_q)
                          : (osc_run && osc_cnt == OSC_LAST);
endmodule

// File: rtl/conv_hold.sv
module conv_hold #(
    parameter int NCH = 4,
    parameter int DW  = 10,
    parameter int CW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [NCH*DW-1:0] live,
    input  logic [CW-1:0]     sel,
    output logic [DW-1:0]     sel_data
);
    logic [NCH-1:0][DW-1:0] live_arr;
    logic [NCH-1:0][DW-1:0] hold_arr;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [DW-1:0] hold_r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hold_r <= '0;
            end else if (capture) begin
                hold_r <= live[g*DW +: DW];
            end
        end
        assign live_arr[g] = live[g*DW +: DW];
        assign hold_arr[g] = hold_r;
    end

    // on the hold tick itself the live value is the one being frozen
    assign sel_data = capture ? live_arr[sel] : hold_arr[sel];
endmodule

// File: rtl/conv_pipe.sv
module conv_pipe #(
    parameter int DEPTH = 8,
    parameter int DW    = 10,
    parameter int CW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          flush,
    input  logic          in_vld,
    input  logic [DW-1:0] in_data,
    input  logic [CW-1:0] in_chan,
    output logic          out_wr,
    output logic [DW-1:0] out_data,
    output logic [CW-1:0] out_chan
);
    logic [DEPTH-1:0]          st_vld;
    logic [DEPTH-1:0][DW-1:0]  st_dat;
    logic [DEPTH-1:0][CW-1:0]  st_chn;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        logic          v_nx;
        logic [DW-1:0] d_nx;
        logic [CW-1:0] c_nx;
        logic          v_r;
        logic [DW-1:0] d_r;
        logic [CW-1:0] c_r;

        if (g == 0) begin : g_head
            assign v_nx = in_vld;
            assign d_nx = in_data;
            assign c_nx = in_chan;
        end else begin : g_body
            assign v_nx = st_vld[g-1];
            assign d_nx = st_dat[g-1];
            assign c_nx = st_chn[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_r <= 1'b0;
                d_r <= '0;
                c_r <= '0;
            end else if (flush) begin
                v_r <= 1'b0;
            end else if (adv) begin
                v_r <= v_nx;
                d_r <= d_nx;
                c_r <= c_nx;
            end
        end

        assign st_vld[g] = v_r;
        assign st_dat[g] = d_r;
        assign st_chn[g] = c_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_wr   <= 1'b0;
            out_data <= '0;
            out_chan <= '0;
        end else if (flush) begin
            out_wr <= 1'b0;
        end else if (adv) begin
            out_wr   <= st_vld[DEPTH-1];
            out_data <= st_dat[DEPTH-1];
            out_chan <= st_chn[DEPTH-1];
        end else begin
            out_wr <= 1'b0;
        end
    end
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import conv_seq_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int DW      = 10,
    parameter int DEPTH   = 8,
    parameter int OSC_DIV = 8,
    localparam int CW     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_single,
    input  logic [CW-1:0]     chan_sel_cnt,
    input  logic              start_n,
    input  logic              conv_clk,
    input  logic [NCH*DW-1:0] ch_sample,
    output logic              fifo_wr,
    output logic [DW-1:0]     fifo_data,
    output logic [CW-1:0]     fifo_chan,
    output logic              busy,
    output logic              busy_err
);
    localparam int DCW = $clog2(DEPTH + 1);
    localparam logic [DCW-1:0] DRAIN_LAST = DCW'(DEPTH - 1);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] idx_q;
    logic [CW-1:0] cnt_lat_q;
    logic [CW-1:0] cnt_use;
    logic [DCW-1:0] drain_q;
    logic          start_q;
    logic          err_q;
    logic          start_fall;
    logic          tick;
    logic          osc_run;
    logic          ext_sel;
    logic          cont_hold;
    logic          scan_hold;
    logic          capture;
    logic          inject;
    logic          flush;
    logic [DW-1:0] sel_data;

    assign start_fall = start_q & ~start_n;
    assign osc_run    = (state_q == ST_SCAN) || (state_q == ST_DRAIN);
    assign ext_sel    = (state_q == ST_CONT);
    assign cont_hold  = (state_q == ST_CONT) && tick && (idx_q == '0);
    assign scan_hold  = (state_q == ST_IDLE) && mode_single && start_fall;
    assign capture    = cont_hold | scan_hold;
    assign cnt_use    = cont_hold ? chan_sel_cnt : cnt_lat_q;
    assign inject     = tick && ((state_q == ST_CONT) || (state_q == ST_SCAN));
    assign flush      = (state_q == ST_CONT) && mode_single;

    conv_tick_gen #(.OSC_DIV(OSC_DIV)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_run  (osc_run),
        .ext_sel  (ext_sel),
        .conv_clk (conv_clk),
        .tick     (tick)
    );

    conv_hold #(.NCH(NCH), .DW(DW), .CW(CW)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .live     (ch_sample),
        .sel      (idx_q),
        .sel_data (sel_data)
    );

    conv_pipe #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (tick),
        .flush    (flush),
        .in_vld   (inject),
        .in_data  (sel_data),
        .in_chan  (idx_q),
        .out_wr   (fifo_wr),
        .out_data (fifo_data),
        .out_chan (fifo_chan)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!mode_single) begin
                    state_d = ST_CONT;
                end else if (start_fall) begin
                    state_d = ST_SCAN;
                end
            end
            ST_CONT: begin
                if (mode_single) begin
                    state_d = ST_IDLE;
                end
            end
            ST_SCAN: begin
                if (tick && idx_q == cnt_lat_q) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (tick && drain_q == DRAIN_LAST) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // sequencing registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            cnt_lat_q <= '0;
            drain_q   <= '0;
            start_q   <= 1'b1;
            err_q     <= 1'b0;
        end else begin
            start_q <= start_n;
            if (capture) begin
                cnt_lat_q <= chan_sel_cnt;
            end
            if (start_fall && osc_run) begin
                err_q <= 1'b1;
            end
            unique case (state_q)
                ST_IDLE: begin
                    idx_q   <= '0;
                    drain_q <= '0;
                end
                ST_CONT: begin
                    if (mode_single) begin
                        idx_q <= '0;
                    end else if (tick) begin
                        idx_q <= (idx_q == cnt_use) ? '0 : idx_q + 1'b1;
                    end
                end
                ST_SCAN: begin
                    drain_q <= '0;
                    if (tick) begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (tick) begin
                        drain_q <= drain_q + 1'b1;
                    end
                end
                default: idx_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy     = osc_run;
        busy_err = err_q;
    end
endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
    parameter int CW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_single,
    input logic          start_n,
    input logic          fifo_wr,
    input logic [CW-1:0] fifo_chan,
    input logic          busy,
    input logic          busy_err
);
    logic [CW-1:0] prev_chan;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_chan <= '0;
        end else if (fifo_wr) begin
            prev_chan <= fifo_chan;
        end
    end

    // R4: every write strobe lasts one cycle
    a_r4_wr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |=> !fifo_wr);

    // R6: a nonzero channel always follows its predecessor
    a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && fifo_chan != '0) |-> (fifo_chan == CW'(prev_chan + 1'b1)));

    // R9: a start edge during a sequence raises the error flag
    a_r9_err_on_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(start_n) && !start_n) |=> busy_err);

    // R9: the error flag is sticky
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        busy_err |=> busy_err);

    // R8: busy ends together with the final write
    a_r8_busy_end_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> fifo_wr);

    // R2: a start edge in steady single mode while idle begins a sequence
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mode_single && $past(mode_single) && $past(start_n) && !start_n) |=> busy);
endmodule

bind conv_sequencer conv_sequencer_chk #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_single (mode_single),
    .start_n     (start_n),
    .fifo_wr     (fifo_wr),
    .fifo_chan   (fifo_chan),
    .busy        (busy),
    .busy_err    (busy_err)
);

// File: tb/conv_sequencer_tb.sv
module conv_sequencer_tb;
    localparam int NCH   = 4;
    localparam int DW    = 10;
    localparam int DEPTH = 8;
    localparam int OSC   = 8;
    localparam int CW    = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              mode_single;
    logic [CW-1:0]     chan_sel_cnt;
    logic              start_n;
    logic              conv_clk;
    logic [NCH*DW-1:0] ch_sample;
    logic              fifo_wr;
    logic [DW-1:0]     fifo_data;
    logic [CW-1:0]     fifo_chan;
    logic              busy;
    logic              busy_err;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int wr_n = 0;
    int wd [0:63];
    int wc [0:63];
    int wt [0:63];
    int tick_cyc [0:63];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    conv_sequencer #(.NCH(NCH), .DW(DW), .DEPTH(DEPTH), .OSC_DIV(OSC)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_single  (mode_single),
        .chan_sel_cnt (chan_sel_cnt),
        .start_n      (start_n),
        .conv_clk     (conv_clk),
        .ch_sample    (ch_sample),
        .fifo_wr      (fifo_wr),
        .fifo_data    (fifo_data),
        .fifo_chan    (fifo_chan),
        .busy         (busy),
        .busy_err     (busy_err)
    );

    always @(negedge clk) begin
        if (fifo_wr && wr_n < 64) begin
            wd[wr_n] = int'(fifo_data);
            wc[wr_n] = int'(fifo_chan);
            wt[wr_n] = cyc;
            wr_n = wr_n + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_live(input int k);
        for (int c = 0; c < NCH; c++) ch_sample[c*DW +: DW] = DW'(k * 4 + c);
    endtask

    task automatic ext_tick(input int k);
        @(negedge clk);
        conv_clk = 1'b1;
        set_live(k);
        tick_cyc[k] = cyc;
        @(negedge clk);
        @(negedge clk);
        conv_clk = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_cont(input int n);
        int t;
        mode_single  = 1'b1;
        chan_sel_cnt = CW'(n - 1);
        repeat (3) @(negedge clk);
        wr_n = 0;
        mode_single = 1'b0;
        repeat (2) @(negedge clk);
        start_n = 1'b0;
        @(negedge clk);
        start_n = 1'b1;
        t = DEPTH + 4 * n;
        for (int k = 1; k <= t; k++) ext_tick(k);
        repeat (4) @(negedge clk);
        chk("R1 continuous start no busy", int'(busy), 0);
        chk("R1 continuous start no error", int'(busy_err), 0);
        chk("R4 write count", wr_n, t - DEPTH);
        for (int j = 0; j < t - DEPTH && j < 64; j++) begin
            chk("R6 channel order", wc[j], j % n);
            chk("R5 set data", wd[j], (n * (j / n) + 1) * 4 + (j % n));
            chk("R7 latency", wt[j], tick_cyc[j + DEPTH + 1] + 1);
        end
    endtask

    task automatic run_single(input int n, input bit second_start);
        int t0;
        int ev;
        mode_single  = 1'b1;
        chan_sel_cnt = CW'(n - 1);
        repeat (3) @(negedge clk);
        wr_n = 0;
        ev = int'(busy_err);
        set_live(50 + n);
        @(negedge clk);
        start_n = 1'b0;
        t0 = cyc;
        @(negedge clk);
        set_live(90);
        chk("R8 busy after start", int'(busy), 1);
        start_n = 1'b1;
        if (second_start) begin
            repeat (20) @(negedge clk);
            chk("R9 no error before", int'(busy_err), 0);
            start_n = 1'b0;
            @(negedge clk);
            start_n = 1'b1;
            @(negedge clk);
            chk("R9 error set", int'(busy_err), 1);
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R11 R3 write count", wr_n, n);
        for (int i = 0; i < n && i < 64; i++) begin
            chk("R6 single channel", wc[i], i);
            chk("R2 held data", wd[i], (50 + n) * 4 + i);
            chk("R3 single timing", wt[i], t0 + 1 + (DEPTH + 1 + i) * OSC);
        end
        chk("R8 busy fell on last write", wt[n - 1], t0 + 1 + (DEPTH + n) * OSC);
        if (second_start) chk("R9 error sticky", int'(busy_err), 1);
        else chk("R9 error unchanged", int'(busy_err), ev);
    endtask

    initial begin
        rst_n        = 1'b0;
        mode_single  = 1'b1;
        chan_sel_cnt = '0;
        start_n      = 1'b1;
        conv_clk     = 1'b0;
        ch_sample    = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset fifo_wr", int'(fifo_wr), 0);
        chk("R12 reset busy", int'(busy), 0);
        chk("R12 reset busy_err", int'(busy_err), 0);

        for (int n = 1; n <= NCH; n++) run_cont(n);

        // R10: count change in the middle of a four-channel set
        mode_single  = 1'b1;
        chan_sel_cnt = CW'(3);
        repeat (3) @(negedge clk);
        wr_n = 0;
        mode_single = 1'b0;
        repeat (2) @(negedge clk);
        ext_tick(1);
        ext_tick(2);
        chan_sel_cnt = CW'(1);
        for (int k = 3; k <= 14; k++) ext_tick(k);
        repeat (4) @(negedge clk);
        chk("R10 write count", wr_n, 6);
        begin
            int ec [0:5];
            int et [0:5];
            ec = '{0, 1, 2, 3, 0, 1};
            et = '{1, 1, 1, 1, 5, 5};
            for (int j = 0; j < 6; j++) begin
                chk("R10 channel", wc[j], ec[j]);
                chk("R10 data", wd[j], et[j] * 4 + ec[j]);
            end
        end

        // delay line is full here; single runs also check R11 flushing
        for (int n = 1; n <= NCH; n++) run_single(n, 1'b0);
        run_single(2, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule